// File: doc/BRIEF.md
# Square-Multiply Sequence Exponent Decoder

This block turns a labelled stream of modular-arithmetic operations back into the exponent that produced it. The stream comes from a left-to-right binary exponentiation. That algorithm squares once for every exponent bit and multiplies once more, straight after the square, whenever the bit is 1. Each label arrives with a valid strobe and carries a one-bit operation code. The block applies the adjacency rule between squares and multiplies to emit one exponent bit per pulse, most significant bit first. It also flags any sequence that the algorithm could not have produced.

A start pulse opens a sequence and clears all state. An end-of-sequence pulse closes it. The block then holds a done flag and the number of bits it recovered until the next start pulse. A multiply that does not directly follow a square is illegal. It raises a sticky error flag, and no further bits are emitted until the next start pulse. The block does not capture traces or classify measurements. It only interprets labels that have already been classified.

Top module: `sqmul_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it is released, bit_valid_o, bit_o, done_o, err_o and bit_count_o are all zero.
- R2: Labels and end pulses that arrive before the first start pulse have no effect: no bit is emitted, and done_o and err_o stay low.
- R3: A start pulse clears the pending-square state, done_o, err_o and bit_count_o. In the next cycle all of them read zero.
- R4: A square (lbl_op_i = 0) followed by another square emits bit 0. bit_valid_o is high for one cycle, starting the cycle after the second square is accepted.
- R5: A square followed by a multiply (lbl_op_i = 1) emits bit 1. The pulse comes the cycle after the multiply is accepted.
- R6: An end pulse (eos_i) that arrives while a square is pending emits bit 0 in the next cycle. done_o rises on that same edge.
- R7: A multiply that opens the sequence or follows a multiply sets err_o. err_o stays high until the next start pulse, and no bit is emitted while it is high. An end pulse still sets done_o.
- R8: bit_count_o equals the number of bit pulses since the last start. It holds its value while done_o is high.
- R9: After done_o rises, labels and end pulses are ignored until the next start pulse.
- R10: A label that arrives in the same cycle as an end pulse is dropped.
- R11: A label that arrives in the same cycle as a start pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Opens a new sequence and clears all state |
| lbl_valid_i | input | 1 | Label strobe |
| lbl_op_i | input | 1 | Operation code: 0 square, 1 multiply |
| eos_i | input | 1 | End-of-sequence pulse |
| bit_valid_o | output | 1 | One-cycle strobe for a recovered exponent bit |
| bit_o | output | 1 | Recovered exponent bit, most significant first |
| done_o | output | 1 | Sequence closed; held until the next start |
| err_o | output | 1 | Illegal adjacency seen; held until the next start |
| bit_count_o | output | CNT_W | Bits recovered since the last start |

## Verification
The properties treat start_i, lbl_valid_i and eos_i as arbitrary. They rely only on inputs being driven to known values once reset is released. No assumption is made about how the three strobes overlap. This lets the source checks for the bit values tolerate collisions between start, end and label. The stimulus deliberately creates those collisions in directed cases. The random sequences are built from random exponents, so they are legal unless a second multiply is deliberately injected. They carry idle gaps of random length, and the bench keeps per-sequence bit counts well below the counter width.

// File: rtl/sqd_pkg.sv
// Shared types for the square-multiply sequence decoder.
package sqd_pkg;

    // Operation code carried by each label.
    typedef enum logic {
        OP_SQUARE = 1'b0,
        OP_MULT   = 1'b1
    } sqd_op_e;

    // One recovered exponent bit as produced by the adjacency logic.
    typedef struct packed {
        logic fire;
        logic value;
    } sqd_bit_t;

endpackage

// File: rtl/sqd_adjacency.sv
// Adjacency interpreter: remembers whether a square is still waiting for its
// successor and decides, per accepted label or end pulse, which bit (if any)
// is complete and whether the label breaks the square/multiply rule.
// Assumes accept and flush are never high together (the controller ensures it).
module sqd_adjacency
    import sqd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clear,
    input  logic     accept,
    input  sqd_op_e  op,
    input  logic     flush,
    output sqd_bit_t emit,
    output logic     illegal
);

    logic pending_q;
    logic pending_d;

    // Resolve the pending square against the incoming label or end pulse.
    always_comb begin
        emit      = '0;
        illegal   = 1'b0;
        pending_d = pending_q;
        if (flush) begin
            emit.fire  = pending_q;
            emit.value = 1'b0;
            pending_d  = 1'b0;
        end else if (accept) begin
            if (op == OP_SQUARE) begin
                emit.fire  = pending_q;
                emit.value = 1'b0;
                pending_d  = 1'b1;
            end else if (pending_q) begin
                emit.fire  = 1'b1;
                emit.value = 1'b1;
                pending_d  = 1'b0;
            end else begin
                illegal = 1'b1;
            end
        end
    end

    // Pending-square register, cleared by reset or start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pending_q <= 1'b0;
        end else begin
            pending_q <= pending_d;
        end
    end

endmodule

// File: rtl/sqd_ctrl.sv
// Sequence controller: tracks armed/done/error state and gates which inputs
// reach the adjacency logic. Start wins over everything, end wins over a label.
// Assumes inputs are synchronous to clk.
module sqd_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic lbl_valid_i,
    input  logic eos_i,
    input  logic illegal,
    output logic clear,
    output logic accept,
    output logic flush,
    output logic done_q,
    output logic err_q
);

    logic armed_q;
    logic open_seq;
    logic live;

    // Derive the gating strobes from the current state.
    always_comb begin
        open_seq = armed_q && !done_q;
        live     = open_seq && !err_q;
        clear    = start_i;
        flush    = !start_i && eos_i && live;
        accept   = !start_i && !eos_i && lbl_valid_i && live;
    end

    // State flags: armed by start, closed by end pulse, poisoned by an error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else if (start_i) begin
            armed_q <= 1'b1;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (eos_i && open_seq) begin
                done_q <= 1'b1;
            end
            if (illegal) begin
                err_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sqd_emitter.sv
// Output stage: registers each completed bit as a one-cycle pulse and counts
// the pulses since the last start. The counter wraps at 2**CNT_W.
module sqd_emitter
    import sqd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  sqd_bit_t         emit,
    output logic             bit_valid_q,
    output logic             bit_q,
    output logic [CNT_W-1:0] count_q
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    // Bit pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            bit_valid_q <= 1'b0;
            bit_q       <= 1'b0;
        end else begin
            bit_valid_q <= emit.fire;
            bit_q       <= emit.fire & emit.value;
        end
    end

    // Recovered-bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count_q <= '0;
        end else if (emit.fire) begin
            count_q <= count_q + CNT_ONE;
        end
    end

endmodule

// File: rtl/sqmul_decoder.sv
// Top level: rebuilds exponent bits, most significant first, from a labelled
// square/multiply stream of a left-to-right binary exponentiation, and flags
// sequences that break the adjacency rule. Synchronous active-low reset.
module sqmul_decoder
    import sqd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             lbl_valid_i,
    input  logic             lbl_op_i,
    input  logic             eos_i,
    output logic             bit_valid_o,
    output logic             bit_o,
    output logic             done_o,
    output logic             err_o,
    output logic [CNT_W-1:0] bit_count_o
);

    logic     clear;
    logic     accept;
    logic     flush;
    logic     illegal;
    sqd_bit_t emit;

    sqd_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .lbl_valid_i (lbl_valid_i),
        .eos_i       (eos_i),
        .illegal     (illegal),
        .clear       (clear),
        .accept      (accept),
        .flush       (flush),
        .done_q      (done_o),
        .err_q       (err_o)
    );

    sqd_adjacency u_adj (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .accept  (accept),
        .op      (sqd_op_e'(lbl_op_i)),
        .flush   (flush),
        .emit    (emit),
        .illegal (illegal)
    );

    sqd_emitter #(.CNT_W(CNT_W)) u_emit (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .emit        (emit),
        .bit_valid_q (bit_valid_o),
        .bit_q       (bit_o),
        .count_q     (bit_count_o)
    );

endmodule

// File: rtl/sqd_checker.sv
// Port-level properties of the decoder, bound into every instance.
module sqd_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             lbl_valid_i,
    input logic             lbl_op_i,
    input logic             eos_i,
    input logic             bit_valid_o,
    input logic             bit_o,
    input logic             done_o,
    input logic             err_o,
    input logic [CNT_W-1:0] bit_count_o
);

    a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_o && !err_o && !bit_valid_o && bit_count_o == '0));

    a_r4_zero_source: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid_o && !bit_o) |-> $past((lbl_valid_i && !lbl_op_i) || eos_i));

    a_r5_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid_o && bit_o) |-> $past(lbl_valid_i && lbl_op_i && !eos_i && !start_i));

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> err_o);

    a_r7_quiet_after_err: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !bit_valid_o);

    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |-> (bit_count_o == $past(bit_count_o) + CNT_W'(1)));

    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && !bit_valid_o && $stable(bit_count_o)));

endmodule

bind sqmul_decoder sqd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .lbl_valid_i (lbl_valid_i),
    .lbl_op_i    (lbl_op_i),
    .eos_i       (eos_i),
    .bit_valid_o (bit_valid_o),
    .bit_o       (bit_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .bit_count_o (bit_count_o)
);

// File: tb/sim_sqmul_decoder.sv
`timescale 1ns/1ps
module sim_sqmul_decoder;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             lbl_valid_i = 1'b0;
    logic             lbl_op_i = 1'b0;
    logic             eos_i = 1'b0;
    logic             bit_valid_o;
    logic             bit_o;
    logic             done_o;
    logic             err_o;
    logic [CNT_W-1:0] bit_count_o;

    int n_chk = 0;
    int n_err = 0;
    int rx_total = 0;
    logic rx [0:2047];

    always #4 clk = ~clk;

    sqmul_decoder #(.CNT_W(CNT_W)) u0 (.*);

    // Collect every emitted bit away from the active edge.
    always @(negedge clk) begin
        if (bit_valid_o) begin
            rx[rx_total % 2048] = bit_o;
            rx_total = rx_total + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic cyc(input logic s, input logic v, input logic op, input logic e);
        @(negedge clk);
        start_i = s; lbl_valid_i = v; lbl_op_i = op; eos_i = e;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
    endtask

    // Expected number of bits: every exponent bit, or up to the injected fault.
    function automatic int exp_count(input int len, input int inj);
        return (inj >= 0) ? inj + 1 : len;
    endfunction

    int   base;
    int   len;
    int   inj;
    int   r;
    logic expb [0:31];

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check("R1 bit_valid in reset", bit_valid_o, 0);
        check("R1 count in reset", bit_count_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", done_o, 0);
        check("R1 err after reset", err_o, 0);

        // R2: stimulus before any start pulse.
        base = rx_total;
        cyc(0, 1, 0, 0); cyc(0, 1, 1, 0); cyc(0, 1, 1, 0); cyc(0, 0, 0, 1); idle(3);
        check("R2 no bits before start", rx_total - base, 0);
        check("R2 no done before start", done_o, 0);
        check("R2 no err before start", err_o, 0);

        // R4 R5 R6: S S M S end -> 0 1 0.
        base = rx_total;
        cyc(1, 0, 0, 0);
        cyc(0, 1, 0, 0); cyc(0, 1, 0, 0); cyc(0, 1, 1, 0); cyc(0, 1, 0, 0);
        cyc(0, 0, 0, 1);
        @(negedge clk);
        check("R6 done with final bit", done_o, 1);
        idle(3);
        check("R8 bit pulses", rx_total - base, 3);
        check("R4 first bit", rx[base % 2048], 0);
        check("R5 second bit", rx[(base + 1) % 2048], 1);
        check("R6 trailing square bit", rx[(base + 2) % 2048], 0);
        check("R8 count", bit_count_o, 3);

        // R9: after done, labels ignored.
        base = rx_total;
        cyc(0, 1, 0, 0); cyc(0, 1, 0, 0); cyc(0, 1, 1, 0); cyc(0, 0, 0, 1); idle(3);
        check("R9 no bits after done", rx_total - base, 0);
        check("R9 count held", bit_count_o, 3);

        // R7: multiply opens the sequence.
        base = rx_total;
        cyc(1, 0, 0, 0);
        cyc(0, 1, 1, 0); cyc(0, 1, 0, 0); cyc(0, 1, 0, 0); cyc(0, 1, 1, 0);
        idle(2);
        check("R7 err on opening multiply", err_o, 1);
        cyc(0, 0, 0, 1); idle(3);
        check("R7 no bits after error", rx_total - base, 0);
        check("R7 err sticky", err_o, 1);
        check("R7 done on end after error", done_o, 1);

        // R3: start clears everything.
        cyc(1, 0, 0, 0); idle(1);
        check("R3 err cleared", err_o, 0);
        check("R3 done cleared", done_o, 0);
        check("R3 count cleared", bit_count_o, 0);

        // R7: multiply after multiply.
        base = rx_total;
        cyc(0, 1, 0, 0); cyc(0, 1, 1, 0); cyc(0, 1, 1, 0); cyc(0, 1, 0, 0); cyc(0, 1, 0, 0);
        cyc(0, 0, 0, 1); idle(3);
        check("R7 double multiply err", err_o, 1);
        check("R7 bits before fault", rx_total - base, 1);
        check("R7 count before fault", bit_count_o, 1);

        // R10: label in the same cycle as end is dropped.
        base = rx_total;
        cyc(1, 0, 0, 0); cyc(0, 1, 0, 0); cyc(0, 1, 1, 1); idle(3);
        check("R10 one bit", rx_total - base, 1);
        check("R10 bit is zero", rx[base % 2048], 0);
        check("R10 no err", err_o, 0);

        // R11: label in the same cycle as start is dropped.
        base = rx_total;
        cyc(1, 1, 1, 0); cyc(0, 1, 0, 0); cyc(0, 0, 0, 1); idle(3);
        check("R11 no err", err_o, 0);
        check("R11 one bit", bit_count_o, 1);

        // Random exponents, some with an injected double multiply.
        for (int s = 0; s < 40; s++) begin
            len = 1 + int'($urandom % 24);
            inj = -1;
            for (int i = 0; i < len; i++) expb[i] = 1'($urandom % 2);
            if (s % 5 == 4) begin
                r = int'($urandom % len);
                for (int i = r; i < len; i++) if (expb[i] && inj < 0) inj = i;
            end
            base = rx_total;
            cyc(1, 0, 0, 0);
            for (int i = 0; i < len; i++) begin
                cyc(0, 1, 0, 0);
                if ($urandom % 3 == 0) idle(int'($urandom % 3));
                if (expb[i]) begin
                    cyc(0, 1, 1, 0);
                    if (i == inj) cyc(0, 1, 1, 0);
                    if ($urandom % 3 == 0) idle(int'($urandom % 3));
                end
            end
            cyc(0, 0, 0, 1); idle(3);
            check("R8 random pulses", rx_total - base, exp_count(len, inj));
            check("R8 random count", bit_count_o, exp_count(len, inj));
            for (int i = 0; i < exp_count(len, inj) && i < rx_total - base; i++)
                check("R4 R5 random bit", rx[(base + i) % 2048], expb[i]);
            check("R7 random err", err_o, (inj >= 0) ? 1 : 0);
            check("R6 random done", done_o, 1);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule